// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte buffer that sits behind a storage controller's FIFO data register when the host moves bytes by programmed I/O. Host writes go into a small data buffer. Host reads take them out in arrival order, and each byte delivered raises a one-cycle interrupt request. The byte count is visible at all times as the FIFO-flags value. When the count drains to zero, both the read and write positions return to the start of the buffer. Because of this, the bytes written after a drain always start again at index 0.

A command-capture mode sends host writes into a separate command buffer, which has its own length counter. In this mode the data buffer is left untouched. Two further strobes serve the controller's sequencer. The first loads a two-byte completion response, made of the status byte and a zero message byte, and sets the count to 2. The second fetches a command without DMA: it reports a bus-id value taken from bits 7:5 of the byte stored at index 2, reports the count at the time of the fetch, and then empties the buffer.

Top module: `pio_byte_fifo`

## Requirements
- R1: After reset, and on the cycle after `flush_i`, the count (`flags_o`), both buffer positions and the command length (`cmd_len_o`) are zero.
- R2: A write outside capture mode, with the count below 15, stores the byte at the write position and raises the count by one. Reads then return the bytes in the order they were written.
- R3: A write while the count is 15 (buffer size 16 minus one) is dropped, leaves the count at 15, and makes `overrun_o` high for exactly one cycle.
- R4: While `capture_i` is high, a write stores the byte in the command buffer at index `cmd_len_o` and raises `cmd_len_o` by one, up to a limit of 32. Writes beyond the limit are dropped. The data buffer count does not change.
- R5: A read with a nonzero count lowers the count by one, presents the byte on `rd_data_o`, and makes `irq_o` high for one cycle. A read with a count of zero changes nothing and raises no interrupt.
- R6: A read while `phase_i` is 0 (the data-out phase) returns 0x00 but still lowers the count and raises the interrupt.
- R7: Whenever the count becomes zero, both positions return to index 0, so the next write lands at index 0.
- R8: `resp_load_i` stores `resp_status_i` at index 0 and 0x00 at index 1, sets the count (and therefore `flags_o`) to 2, and resets both positions.
- R9: `cmd_fetch_i` sets `busid_o` to bits 7:5 of the byte at index 2 (that is, the byte shifted right by 5), sets `fetch_len_o` to the count at the time of the fetch, and clears the count and the positions.
- R10: When several operations arrive in the same cycle, only one is performed, in this priority: flush, response load, fetch, read, write. The lower-priority operations are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Clear count, positions and command length |
| capture_i | input | 1 | Command-capture mode active |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host read strobe |
| phase_i | input | 3 | Bus phase field; 0 means data-out |
| resp_load_i | input | 1 | Load the two-byte completion response |
| resp_status_i | input | 8 | Status byte for the response |
| cmd_fetch_i | input | 1 | Fetch the command from the buffer |
| cmd_rd_idx_i | input | 5 | Command buffer read index |
| rd_data_o | output | 8 | Last byte delivered to the host |
| irq_o | output | 1 | One-cycle pulse for each byte delivered |
| overrun_o | output | 1 | One-cycle pulse for each dropped write |
| flags_o | output | 5 | Byte count |
| cmd_len_o | output | 6 | Command buffer length |
| cmd_rd_data_o | output | 8 | Command buffer byte at `cmd_rd_idx_i` |
| busid_o | output | 8 | Bus-id value from the last fetch |
| fetch_len_o | output | 5 | Count at the time of the last fetch |

## Verification
Every result except `cmd_rd_data_o` comes from a register that updates on the first rising edge after the cycle in which the strobe is held. So the count, read byte, interrupt, overrun, bus-id and fetch length are all due exactly one cycle after the stimulus. The bench applies each strobe at a falling edge, removes it at the next falling edge, and checks there. This is half a cycle after the update and well clear of the edge. The two pulses are checked again one cycle later to confirm they have returned low. The command buffer read port is combinational, so it is checked in the same cycle that its index is driven.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    // Single operation granted per cycle, listed from highest priority down
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_FLUSH,
        OP_RESP,
        OP_FETCH,
        OP_READ,
        OP_WRITE,
        OP_CAPTURE
    } pfifo_op_e;

    function automatic pfifo_op_e pick_op(input logic flush, input logic resp,
                                          input logic fetch, input logic rd,
                                          input logic wr, input logic capture);
        if (flush)        return OP_FLUSH;
        else if (resp)    return OP_RESP;
        else if (fetch)   return OP_FETCH;
        else if (rd)      return OP_READ;
        else if (wr)      return capture ? OP_CAPTURE : OP_WRITE;
        else              return OP_IDLE;
    endfunction

endpackage

// File: rtl/pfifo_data_store.sv
module pfifo_data_store #(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              resp_ld,
    input  logic [BYTE_W-1:0] resp_byte,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] third_byte
);
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (resp_ld) begin
            mem_q[0] <= resp_byte;
            mem_q[1] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata      = mem_q[raddr];
    assign third_byte = mem_q[2];
endmodule

// File: rtl/pfifo_cmd_store.sv
module pfifo_cmd_store #(
    parameter int DEPTH  = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo
    import pfifo_pkg::*;
#(
    parameter int DATA_DEPTH  = 16,
    parameter int CMD_DEPTH   = 32,
    parameter int BYTE_W      = 8,
    parameter int PHASE_W     = 3,
    parameter int BUSID_SHIFT = 5,
    localparam int PTR_W  = $clog2(DATA_DEPTH),
    localparam int CNT_W  = PTR_W + 1,
    localparam int CIDX_W = $clog2(CMD_DEPTH),
    localparam int CLEN_W = CIDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               capture_i,
    input  logic               wr_en_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    input  logic               rd_en_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               resp_load_i,
    input  logic [BYTE_W-1:0]  resp_status_i,
    input  logic               cmd_fetch_i,
    input  logic [CIDX_W-1:0]  cmd_rd_idx_i,
    output logic [BYTE_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic               overrun_o,
    output logic [CNT_W-1:0]   flags_o,
    output logic [CLEN_W-1:0]  cmd_len_o,
    output logic [BYTE_W-1:0]  cmd_rd_data_o,
    output logic [BYTE_W-1:0]  busid_o,
    output logic [CNT_W-1:0]   fetch_len_o
);
    localparam logic [CNT_W-1:0]  CNT_LIMIT = CNT_W'(DATA_DEPTH - 1);
    localparam logic [CLEN_W-1:0] CLEN_MAX  = CLEN_W'(CMD_DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PTR_W-1:0]  rptr;
        logic [PTR_W-1:0]  wptr;
        logic [CLEN_W-1:0] clen;
        logic [BYTE_W-1:0] rdata;
        logic              irq;
        logic              ovr;
        logic [BYTE_W-1:0] busid;
        logic [CNT_W-1:0]  flen;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    pfifo_op_e op_d;
    logic      data_we_d, cmd_we_d, resp_ld_d;
    logic [BYTE_W-1:0] head_byte, third_byte;

    pfifo_data_store #(.DEPTH(DATA_DEPTH), .BYTE_W(BYTE_W), .ADDR_W(PTR_W)) data_i (
        .clk        (clk),
        .we         (data_we_d),
        .waddr      (ctl_q.wptr),
        .wdata      (wr_data_i),
        .resp_ld    (resp_ld_d),
        .resp_byte  (resp_status_i),
        .raddr      (ctl_q.rptr),
        .rdata      (head_byte),
        .third_byte (third_byte)
    );

    pfifo_cmd_store #(.DEPTH(CMD_DEPTH), .BYTE_W(BYTE_W), .ADDR_W(CIDX_W)) cmd_i (
        .clk   (clk),
        .we    (cmd_we_d),
        .waddr (ctl_q.clen[CIDX_W-1:0]),
        .wdata (wr_data_i),
        .raddr (cmd_rd_idx_i),
        .rdata (cmd_rd_data_o)
    );

    always_comb begin
        op_d      = pick_op(flush_i, resp_load_i, cmd_fetch_i, rd_en_i, wr_en_i, capture_i);
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        ctl_d.ovr = 1'b0;
        data_we_d = 1'b0;
        cmd_we_d  = 1'b0;
        resp_ld_d = 1'b0;
        unique case (op_d)
            OP_FLUSH: begin
                ctl_d.cnt  = '0;
                ctl_d.rptr = '0;
                ctl_d.wptr = '0;
                ctl_d.clen = '0;
            end
            OP_RESP: begin
                resp_ld_d  = 1'b1;
                ctl_d.cnt  = CNT_W'(2);
                ctl_d.rptr = '0;
                ctl_d.wptr = '0;
            end
            OP_FETCH: begin
                ctl_d.busid = third_byte >> BUSID_SHIFT;
                ctl_d.flen  = ctl_q.cnt;
                ctl_d.cnt   = '0;
                ctl_d.rptr  = '0;
                ctl_d.wptr  = '0;
            end
            OP_READ: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                    ctl_d.irq = 1'b1;
                    if (phase_i == '0) begin
                        ctl_d.rdata = '0;
                    end else begin
                        ctl_d.rdata = head_byte;
                        ctl_d.rptr  = ctl_q.rptr + 1'b1;
                    end
                end
                if (ctl_d.cnt == '0) begin
                    ctl_d.rptr = '0;
                    ctl_d.wptr = '0;
                end
            end
            OP_WRITE: begin
                if (ctl_q.cnt == CNT_LIMIT) begin
                    ctl_d.ovr = 1'b1;
                end else begin
                    data_we_d  = 1'b1;
                    ctl_d.wptr = ctl_q.wptr + 1'b1;
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                end
            end
            OP_CAPTURE: begin
                if (ctl_q.clen < CLEN_MAX) begin
                    cmd_we_d   = 1'b1;
                    ctl_d.clen = ctl_q.clen + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_data_o   = ctl_q.rdata;
    assign irq_o       = ctl_q.irq;
    assign overrun_o   = ctl_q.ovr;
    assign flags_o     = ctl_q.cnt;
    assign cmd_len_o   = ctl_q.clen;
    assign busid_o     = ctl_q.busid;
    assign fetch_len_o = ctl_q.flen;
endmodule

// File: rtl/pfifo_checker.sv
module pfifo_checker #(
    parameter int DATA_DEPTH = 16,
    parameter int CMD_DEPTH  = 32,
    parameter int CNT_W      = 5,
    parameter int PTR_W      = 4,
    parameter int CLEN_W     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              capture_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              resp_load_i,
    input logic              cmd_fetch_i,
    input logic              irq_o,
    input logic              overrun_o,
    input logic [CNT_W-1:0]  flags_o,
    input logic [CLEN_W-1:0] cmd_len_o,
    input logic [PTR_W-1:0]  rptr,
    input logic [PTR_W-1:0]  wptr
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o <= CNT_W'(DATA_DEPTH - 1)); // R2

    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> (flags_o == CNT_W'(DATA_DEPTH - 1)) && (flags_o == $past(flags_o))); // R3

    AST_CAPTURE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && wr_en_i && !flush_i && !resp_load_i && !cmd_fetch_i && !rd_en_i)
        |=> $stable(flags_o)); // R4

    AST_CMD_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_len_o <= CLEN_W'(CMD_DEPTH)); // R4

    AST_IRQ_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flags_o == CNT_W'($past(flags_o) - 1'b1)); // R5

    AST_EMPTY_PTRS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o == '0) |-> (rptr == '0 && wptr == '0)); // R7

    AST_RESP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_load_i && !flush_i) |=> flags_o == CNT_W'(2)); // R8

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (flags_o == '0 && cmd_len_o == '0)); // R1
endmodule

bind pio_byte_fifo pfifo_checker #(
    .DATA_DEPTH (DATA_DEPTH),
    .CMD_DEPTH  (CMD_DEPTH),
    .CNT_W      (CNT_W),
    .PTR_W      (PTR_W),
    .CLEN_W     (CLEN_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .capture_i   (capture_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .resp_load_i (resp_load_i),
    .cmd_fetch_i (cmd_fetch_i),
    .irq_o       (irq_o),
    .overrun_o   (overrun_o),
    .flags_o     (flags_o),
    .cmd_len_o   (cmd_len_o),
    .rptr        (ctl_q.rptr),
    .wptr        (ctl_q.wptr)
);

// File: tb/pio_byte_fifo_tb.sv
`timescale 1ns/1ps
module pio_byte_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_i = 0, capture_i = 0, wr_en_i = 0, rd_en_i = 0;
    logic [7:0] wr_data_i = 0, resp_status_i = 0;
    logic [2:0] phase_i = 3'd1;
    logic       resp_load_i = 0, cmd_fetch_i = 0;
    logic [4:0] cmd_rd_idx_i = 0;
    logic [7:0] rd_data_o, cmd_rd_data_o, busid_o;
    logic       irq_o, overrun_o;
    logic [4:0] flags_o, fetch_len_o;
    logic [5:0] cmd_len_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    always #2 clk = ~clk;

    pio_byte_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .capture_i(capture_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .phase_i(phase_i), .resp_load_i(resp_load_i), .resp_status_i(resp_status_i),
        .cmd_fetch_i(cmd_fetch_i), .cmd_rd_idx_i(cmd_rd_idx_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o), .overrun_o(overrun_o),
        .flags_o(flags_o), .cmd_len_o(cmd_len_o), .cmd_rd_data_o(cmd_rd_data_o),
        .busid_o(busid_o), .fetch_len_o(fetch_len_o)
    );

    typedef struct packed {
        logic       rd;
        logic [7:0] wdata;
        logic [7:0] exp_data;
        logic [4:0] exp_cnt;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 8'h11, 8'h00, 5'd1},
        '{1'b0, 8'h22, 8'h00, 5'd2},
        '{1'b0, 8'h33, 8'h00, 5'd3},
        '{1'b1, 8'h00, 8'h11, 5'd2},
        '{1'b1, 8'h00, 8'h22, 5'd1},
        '{1'b0, 8'h44, 8'h00, 5'd2},
        '{1'b1, 8'h00, 8'h33, 5'd1},
        '{1'b1, 8'h00, 8'h44, 5'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Hold whatever strobes were set for one cycle, then release them all
    task automatic cycle();
        @(negedge clk);
        flush_i = 0; wr_en_i = 0; rd_en_i = 0; resp_load_i = 0; cmd_fetch_i = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1; wr_data_i = d; cycle();
    endtask

    task automatic rd();
        rd_en_i = 1; cycle();
    endtask

    task automatic flush();
        flush_i = 1; cycle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset count", flags_o, 0);
        check("R1 reset cmd_len", cmd_len_o, 0);
        check("R5 reset irq", irq_o, 0);
        check("R3 reset overrun", overrun_o, 0);

        // Vector table: R2 ordering, R5 read and interrupt, R7 drain
        foreach (VECS[i]) begin
            if (VECS[i].rd) begin
                rd();
                check("R5 read data", rd_data_o, VECS[i].exp_data);
                check("R5 irq pulse", irq_o, 1);
            end else begin
                wr(VECS[i].wdata);
                check("R2 write no irq", irq_o, 0);
            end
            check("R2 count", flags_o, VECS[i].exp_cnt);
        end

        // R5 read at empty: nothing changes
        rd();
        check("R5 empty read irq", irq_o, 0);
        check("R5 empty read count", flags_o, 0);
        check("R5 empty read data kept", rd_data_o, 8'h44);

        // R3 overrun one before full
        for (int i = 0; i < 15; i++) wr(8'h80 + 8'(i));
        check("R3 count at limit", flags_o, 15);
        wr(8'hEE);
        check("R3 overrun pulse", overrun_o, 1);
        check("R3 count held", flags_o, 15);
        cycle();
        check("R3 overrun one cycle", overrun_o, 0);
        for (int i = 0; i < 15; i++) begin
            rd();
            check("R3 drain data (dropped byte absent)", rd_data_o, 8'h80 + i);
        end
        check("R7 drained count", flags_o, 0);

        // R6 data-out phase returns zero
        wr(8'h5A);
        phase_i = 3'd0;
        rd();
        check("R6 phase zero data", rd_data_o, 0);
        check("R6 phase zero irq", irq_o, 1);
        check("R6 phase zero count", flags_o, 0);
        phase_i = 3'd1;

        // R7 positions return home after drain, seen through the fetch of index 2
        wr(8'hA1); wr(8'hB2); wr(8'hC3);
        rd(); rd(); rd();
        wr(8'h11); wr(8'h22); wr(8'hE3);
        cmd_fetch_i = 1; cycle();
        check("R7 new bytes at index 0", busid_o, 7);
        // R9 fetch results
        check("R9 fetch length", fetch_len_o, 3);
        check("R9 fetch clears count", flags_o, 0);
        wr(8'h00); wr(8'h00); wr(8'h40); wr(8'h99);
        cmd_fetch_i = 1; cycle();
        check("R9 busid from third byte", busid_o, 2);
        check("R9 fetch length 4", fetch_len_o, 4);

        // R8 completion response
        resp_status_i = 8'h02; resp_load_i = 1; cycle();
        check("R8 flags two", flags_o, 2);
        rd();
        check("R8 status byte", rd_data_o, 8'h02);
        rd();
        check("R8 message byte", rd_data_o, 8'h00);
        check("R8 drained", flags_o, 0);

        // R4 command capture
        capture_i = 1;
        for (int i = 0; i < 33; i++) wr(8'h40 + 8'(i));
        check("R4 cmd_len saturates", cmd_len_o, 32);
        check("R4 data count untouched", flags_o, 0);
        cmd_rd_idx_i = 5'd0; #1;
        check("R4 cmd byte 0", cmd_rd_data_o, 8'h40);
        cmd_rd_idx_i = 5'd31; #1;
        check("R4 cmd byte 31", cmd_rd_data_o, 8'h5F);
        capture_i = 0;

        // R10 priority: flush beats write, response beats write
        wr(8'h77);
        flush_i = 1; wr_en_i = 1; wr_data_i = 8'h66; cycle();
        check("R10 flush over write", flags_o, 0);
        check("R1 flush clears cmd_len", cmd_len_o, 0);
        resp_status_i = 8'h08; resp_load_i = 1; wr_en_i = 1; wr_data_i = 8'hFF; cycle();
        check("R10 resp over write count", flags_o, 2);
        rd();
        check("R10 resp over write data", rd_data_o, 8'h08);
        wr(8'h31);
        rd_en_i = 1; wr_en_i = 1; wr_data_i = 8'hAB; cycle();
        check("R10 read over write count", flags_o, 1);
        check("R10 read over write data", rd_data_o, 8'h00);
        flush();
        check("R1 flush count", flags_o, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule